// File: doc/BRIEF.md
# Global-History Two-Level Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shift register with the outcomes of the most recent resolved conditional branches. That register value selects a 2-bit saturating counter in a pattern table. No branch address bits enter the index, so every branch that sees the same recent outcome pattern shares one counter.

A front end raises `lkp_valid` and reads `pred_taken` in the same cycle. When the branch resolves, the back end raises `upd_valid` with the real outcome on `upd_taken`. The block then trains the counter that produced the prediction and shifts the outcome into the history. Only one branch may be in flight between its lookup and its update. An update may share a cycle with the next lookup.

Top module: `gpred_top`

## Requirements
- R1: A synchronous reset clears the history to zero and sets every counter to 1, so the first lookup after reset predicts not-taken.
- R2: The pattern table is indexed by the global history value alone, so a counter trained under one history pattern is found again when that pattern recurs.
- R3: Counters hold 0 to 3. A lookup predicts taken (`pred_taken` = 1) exactly when the selected counter is 2 or 3.
- R4: On an update, the history shifts left by one, the oldest bit drops out and the outcome enters bit 0 (1 = taken). Without an update the history holds.
- R5: A taken update increments the trained counter and saturates at 3.
- R6: A not-taken update decrements the trained counter and saturates at 0.
- R7: An update trains the counter selected by the history captured at the most recent lookup, not by the history after shifting.
- R8: When a lookup and an update occur in the same cycle, the lookup's prediction reflects the table and history from before that update.
- R9: `pred_taken` is 0 in any cycle where `lkp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lkp_valid | input | 1 | Lookup request this cycle |
| pred_taken | output | 1 | Predicted direction for the current lookup, 1 = taken |
| upd_valid | input | 1 | Resolved outcome present this cycle |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest state to reach from the ports is a counter at a known value, revisited under the same history while that history is still zero. Reaching it takes one taken outcome at index zero, followed by exactly as many not-taken outcomes as the history is long. Those outcomes walk the register back to zero. From there the stimulus overlaps each update with the next lookup. This exposes whether a lookup sees pre-update state, and whether repeated not-taken outcomes at index zero saturate or wrap. A second vector run of all-taken outcomes fills the history with ones, so one counter is driven through its upper saturation.

// File: rtl/gpred_pkg.sv
package gpred_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN  = 2'd0;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_INIT = 2'd1;

  // saturating 2-bit counter step
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else       r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    return r;
  endfunction

  // upper half of the range means taken
  function automatic logic ctr_says_taken(input ctr_t c);
    return c >= 2'd2;
  endfunction

endpackage

// File: rtl/gpred_history.sv
module gpred_history #(
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
  end

  assign hist = hist_q;

endmodule

// File: rtl/gpred_pending.sv
module gpred_pending #(
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [HIST_W-1:0] cap_idx,
  output logic [HIST_W-1:0] idx
);

  logic [HIST_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (cap_en) idx_q <= cap_idx;
  end

  assign idx = idx_q;

endmodule

// File: rtl/gpred_pattern_table.sv
module gpred_pattern_table
  import gpred_pkg::*;
#(
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HIST_W-1:0] rd_idx,
  output ctr_t              rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken,
  output ctr_t              wr_ctr
);

  localparam int DEPTH = 1 << HIST_W;

  ctr_t ctr_q [DEPTH];
  ctr_t wr_next;

  assign rd_ctr  = ctr_q[rd_idx];
  assign wr_ctr  = ctr_q[wr_idx];
  assign wr_next = ctr_step(wr_ctr, wr_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_next;
    end
  end

endmodule

// File: rtl/gpred_top.sv
module gpred_top
  import gpred_pkg::*;
#(
  parameter int HIST_W = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic lkp_valid,
  output logic pred_taken,
  input  logic upd_valid,
  input  logic upd_taken
);

  // named events for the checker
  logic              lkp_fire;
  logic              upd_fire;
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] pend_idx;
  ctr_t              lkp_ctr;
  ctr_t              upd_ctr;

  assign lkp_fire = lkp_valid;
  assign upd_fire = upd_valid;

  gpred_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (upd_fire),
    .shift_bit (upd_taken),
    .hist      (hist_q)
  );

  gpred_pending #(.HIST_W(HIST_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (lkp_fire),
    .cap_idx (hist_q),
    .idx     (pend_idx)
  );

  gpred_pattern_table #(.HIST_W(HIST_W)) u_pht (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (hist_q),
    .rd_ctr   (lkp_ctr),
    .wr_en    (upd_fire),
    .wr_idx   (pend_idx),
    .wr_taken (upd_taken),
    .wr_ctr   (upd_ctr)
  );

  assign pred_taken = lkp_fire && ctr_says_taken(lkp_ctr);

endmodule

// File: rtl/gpred_checker.sv
module gpred_checker #(
  parameter int HIST_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              lkp_fire,
  input logic              upd_fire,
  input logic              upd_taken,
  input logic              pred_taken,
  input logic [HIST_W-1:0] hist_q,
  input logic [HIST_W-1:0] pend_idx,
  input logic [1:0]        upd_ctr
);

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken)}); // R4
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_fire |=> $stable(hist_q)); // R4
  AST_CTR_INC_SAT: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !lkp_fire && upd_taken) |=>
      upd_ctr == (($past(upd_ctr) == 2'd3) ? 2'd3 : $past(upd_ctr) + 2'd1)); // R5
  AST_CTR_DEC_SAT: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !lkp_fire && !upd_taken) |=>
      upd_ctr == (($past(upd_ctr) == 2'd0) ? 2'd0 : $past(upd_ctr) - 2'd1)); // R6
  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    lkp_fire |=> pend_idx == $past(hist_q)); // R7
  AST_NO_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lkp_fire |-> !pred_taken); // R9

endmodule

bind gpred_top gpred_checker #(.HIST_W(HIST_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lkp_fire   (lkp_fire),
  .upd_fire   (upd_fire),
  .upd_taken  (upd_taken),
  .pred_taken (pred_taken),
  .hist_q     (hist_q),
  .pend_idx   (pend_idx),
  .upd_ctr    (upd_ctr)
);

// File: tb/sim_gpred_top.sv
module sim_gpred_top;

  localparam int HIST_W = 11;
  localparam int NVEC   = 17;
  // each vector: {outcome, expected prediction}; history starts at zero
  localparam logic [1:0] VEC [NVEC] = '{
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11, 2'b01, 2'b00, 2'b10
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lkp_valid = 1'b0;
  logic upd_valid = 1'b0;
  logic upd_taken = 1'b0;
  logic pred_taken;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpred_top #(.HIST_W(HIST_W)) u0 (
    .clk        (clk),
    .rst        (rst),
    .lkp_valid  (lkp_valid),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pred_taken=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic op(input logic lk, input logic up, input logic ut, output logic p);
    @(negedge clk);
    lkp_valid = lk;
    upd_valid = up;
    upd_taken = ut;
    #2;
    p = pred_taken;
  endtask

  task automatic idle();
    @(negedge clk);
    lkp_valid = 1'b0;
    upd_valid = 1'b0;
    upd_taken = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    lkp_valid = 1'b0;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic p;
    do_reset();

    // vector walk: lookup, compare, then resolve
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      if (i < 12)       tag = "R2";
      else if (i == 12) tag = "R3";
      else if (i < 15)  tag = "R5";
      else if (i == 15) tag = "R6";
      else              tag = "R7";
      op(1'b1, 1'b0, 1'b0, p);
      check(tag, p, VEC[i][0]);
      op(1'b0, 1'b1, VEC[i][1], p);
    end
    idle();

    // R1: index 0 held 2 before reset; reset returns it to 1
    do_reset();
    op(1'b1, 1'b0, 1'b0, p);
    check("R1", p, 1'b0);
    op(1'b0, 1'b1, 1'b1, p);          // index 0 -> 2, history 1

    // R4: not-taken outcomes walk history back to zero via fresh entries
    for (int k = 0; k < HIST_W; k++) begin
      op(1'b1, 1'b0, 1'b0, p);
      check("R4", p, 1'b0);
      op(1'b0, 1'b1, 1'b0, p);
    end

    op(1'b0, 1'b0, 1'b0, p);
    check("R9", p, 1'b0);              // counter at index 0 is 2, no lookup
    op(1'b1, 1'b0, 1'b0, p);
    check("R2", p, 1'b1);              // same history, trained counter found
    op(1'b1, 1'b1, 1'b0, p);
    check("R8", p, 1'b1);              // sees 2, not the post-update 1
    op(1'b1, 1'b1, 1'b0, p);
    check("R6", p, 1'b0);              // counter 1; update drives it to 0
    op(1'b1, 1'b1, 1'b0, p);
    check("R6", p, 1'b0);              // counter 0; update must stay at 0
    op(1'b1, 1'b0, 1'b0, p);
    check("R6", p, 1'b0);              // a wrap to 3 would predict taken
    op(1'b0, 1'b1, 1'b1, p);
    idle();
    idle();
    finish_run();
  end

endmodule